// File: doc/BRIEF.md
# Reloading Down-Count Timer Unit

The unit holds several independent down-counting channels that share one clock and one free-running prescaler. Each channel has three registers: a live counter, a reload value and a control word. The control word picks the tick rate, enables the channel's interrupt and holds a sticky expiry flag. A shared run register starts and freezes the channels one bit at a time. When a running channel ticks while its counter is zero, the counter takes the reload value, the expiry flag is set, and the interrupt output goes high if it is enabled.

Software can use a channel in three ways:
- **Periodic event source:** load the period into the reload register.
- **Single-shot delay:** load zero into the reload register, so the counter stays at zero after the first expiry.
- **Timestamp:** load all ones into both registers. The channel then counts down freely, and its bitwise inverse counts up.

All access goes through a simple synchronous register port. Writes take effect on the clock edge. Read data is combinational from the current address.

Top module: `dtimer_unit`

## Requirements
- R1: After reset every counter and reload register reads all ones, every control word reads 0, the run register reads 0 and every interrupt output is low.
- R2: Bit k of the run register (offset 0x00, bits NCH-1:0) lets channel k count. While that bit is 0 the counter holds its value.
- R3: A running channel whose counter is not zero decrements by exactly one per tick. Tick rate is the clock divided by 4^(s+1), where s is the select field in control bits 2:0 (s=0 is /4, s=1 is /16).
- R4: A tick on a running channel whose counter is zero loads the reload value and sets the expiry flag (control bit 8). With reload value N, expiries repeat every N+1 ticks.
- R5: The expiry flag stays set until a control write carries 0 in bit 8. A control write with bit 8 at 1 leaves the flag unchanged.
- R6: When an expiry and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R7: Interrupt output k is high exactly when channel k's expiry flag and its enable bit (control bit 5) are both 1.
- R8: A counter write loads the written value on that clock edge and overrides any decrement or reload in the same cycle.
- R9: With reload value 0 the counter stays at 0 after the first expiry.
- R10: Channel k's counter is at 0x04+0x10*k, its reload register at 0x08+0x10*k and its control word at 0x0C+0x10*k. Unmapped addresses read 0 and ignore writes.
- R11: Writes to one channel and its run bit do not change another channel's counter, reload value or control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq | output | NCH | Level interrupt per channel |

## Verification
A wrong counter, reload value or flag is visible at the ports in the cycle after the edge that caused it. The visible effect is either a mismatched read value or a mismatched interrupt level. A prescaler that is off by one edge shifts every decrement. That shift shows up as a wrong counter value within one tick period, which is 4 cycles at the fastest setting. Set-versus-clear ordering is forced by aiming a clearing write at the exact edge where an expiry occurs. Its effect shows as a missing flag on the next read.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
// dtu_pkg: shared constants for the reloading timer unit.
// Assumes byte addressing with 32-bit word-aligned registers.
package dtu_pkg;
    localparam int SEL_W     = 3;               // width of the tick-rate select field
    localparam int NTAP      = 1 << SEL_W;      // number of prescaler taps
    localparam int PRE_W     = 2 * NTAP;        // prescaler width, /4 per step
    localparam int IE_BIT    = 5;               // interrupt enable position
    localparam int FLAG_BIT  = 8;               // expiry flag position
    localparam int START_OFS = 0;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 16;
    localparam int CNT_OFS   = 0;
    localparam int RLD_OFS   = 4;
    localparam int CTL_OFS   = 8;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic int ch_addr(input int k, input int ofs);
        return CH_BASE + k * CH_STRIDE + ofs;
    endfunction
endpackage

// File: rtl/dtu_prescaler.sv
`timescale 1ns/1ps
// dtu_prescaler: free-running counter shared by all channels.
// Tap n pulses for one cycle every 4^(n+1) cycles.
// Assumes the taps are sampled as single-cycle enables.
module dtu_prescaler
    import dtu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [NTAP-1:0] tap
);
    logic [PRE_W-1:0] pre_q;

    // Advance the shared prescaler every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Tap n is high when the low 2(n+1) bits are all ones.
    for (genvar n = 0; n < NTAP; n++) begin : g_tap
        assign tap[n] = &pre_q[2*n+1:0];
    end
endmodule

// File: rtl/dtu_channel.sv
`timescale 1ns/1ps
// dtu_channel: one down-counting channel with reload, control and flag.
// Assumes the write strobes are already decoded and mutually exclusive.
// A counter write overrides counting and suppresses expiry for that cycle.
module dtu_channel
    import dtu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [NTAP-1:0] tap,
    input  logic [DW-1:0]   wdata,
    input  logic            cnt_we,
    input  logic            rld_we,
    input  logic            ctl_we,
    output logic [DW-1:0]   cnt_q,
    output logic [DW-1:0]   rld_q,
    output logic [DW-1:0]   ctl_rd,
    output logic            tick,
    output logic            uflow,
    output logic            flag,
    output logic            irq
);
    ctl_t ctl_q;

    assign tick  = tap[ctl_q.sel];
    assign uflow = run & tick & (cnt_q == '0) & ~cnt_we;
    assign flag  = ctl_q.flag;
    assign irq   = ctl_q.flag & ctl_q.ie;

    // Counter: software load, else decrement or reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '1;
        else if (cnt_we)       cnt_q <= wdata;
        else if (run && tick)  cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
    end

    // Reload register: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '1;
        else if (rld_we) rld_q <= wdata;
    end

    // Control word: select and enable from writes; flag set-wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (ctl_we) begin
                ctl_q.sel <= wdata[SEL_W-1:0];
                ctl_q.ie  <= wdata[IE_BIT];
            end
            ctl_q.flag <= uflow | (ctl_q.flag & ~(ctl_we & ~wdata[FLAG_BIT]));
        end
    end

    // Read-back image of the control word.
    always_comb begin
        ctl_rd               = '0;
        ctl_rd[SEL_W-1:0]    = ctl_q.sel;
        ctl_rd[IE_BIT]       = ctl_q.ie;
        ctl_rd[FLAG_BIT]     = ctl_q.flag;
    end
endmodule

// File: rtl/dtu_regbus.sv
`timescale 1ns/1ps
// dtu_regbus: address decode and read multiplexer for the timer unit.
// Assumes word-aligned addresses. Unmapped addresses read zero.
module dtu_regbus
    import dtu_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [NCH-1:0]          run_q,
    input  logic [NCH-1:0][DW-1:0]  cnt_v,
    input  logic [NCH-1:0][DW-1:0]  rld_v,
    input  logic [NCH-1:0][DW-1:0]  ctl_v,
    output logic                    start_we,
    output logic [NCH-1:0]          cnt_we,
    output logic [NCH-1:0]          rld_we,
    output logic [NCH-1:0]          ctl_we,
    output logic [DW-1:0]           rdata
);
    localparam logic [AW-1:0] A_START = AW'(START_OFS);

    logic           start_hit;
    logic [NCH-1:0] cnt_hit, rld_hit, ctl_hit;

    assign start_hit = (bus_addr == A_START);
    assign start_we  = bus_we & start_hit;

    for (genvar k = 0; k < NCH; k++) begin : g_dec
        localparam logic [AW-1:0] A_CNT = AW'(ch_addr(k, CNT_OFS));
        localparam logic [AW-1:0] A_RLD = AW'(ch_addr(k, RLD_OFS));
        localparam logic [AW-1:0] A_CTL = AW'(ch_addr(k, CTL_OFS));
        assign cnt_hit[k] = (bus_addr == A_CNT);
        assign rld_hit[k] = (bus_addr == A_RLD);
        assign ctl_hit[k] = (bus_addr == A_CTL);
        assign cnt_we[k]  = bus_we & cnt_hit[k];
        assign rld_we[k]  = bus_we & rld_hit[k];
        assign ctl_we[k]  = bus_we & ctl_hit[k];
    end

    // Select the addressed register for read-back.
    always_comb begin
        rdata = '0;
        if (start_hit) rdata[NCH-1:0] = run_q;
        for (int k = 0; k < NCH; k++) begin
            if (cnt_hit[k]) rdata = cnt_v[k];
            if (rld_hit[k]) rdata = rld_v[k];
            if (ctl_hit[k]) rdata = ctl_v[k];
        end
    end
endmodule

// File: rtl/dtimer_unit.sv
`timescale 1ns/1ps
// dtimer_unit: register-mapped multi-channel reloading down-count timer.
// Assumes one clock domain and a synchronous active-low reset.
// The shared run register holds one bit per channel.
module dtimer_unit
    import dtu_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    logic [NTAP-1:0]        tap;
    logic [NCH-1:0]         run_q;
    logic                   start_we;
    logic [NCH-1:0]         cnt_we, rld_we, ctl_we;
    logic [NCH-1:0][DW-1:0] cnt_v, rld_v, ctl_v;
    logic [NCH-1:0]         ch_tick, ch_uflow, ch_flag;

    // Shared run register: one enable bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (start_we) run_q <= bus_wdata[NCH-1:0];
    end

    dtu_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (tap)
    );

    dtu_regbus #(.NCH(NCH), .DW(DW), .AW(AW)) u_bus (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .run_q    (run_q),
        .cnt_v    (cnt_v),
        .rld_v    (rld_v),
        .ctl_v    (ctl_v),
        .start_we (start_we),
        .cnt_we   (cnt_we),
        .rld_we   (rld_we),
        .ctl_we   (ctl_we),
        .rdata    (bus_rdata)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        dtu_channel #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[k]),
            .tap    (tap),
            .wdata  (bus_wdata),
            .cnt_we (cnt_we[k]),
            .rld_we (rld_we[k]),
            .ctl_we (ctl_we[k]),
            .cnt_q  (cnt_v[k]),
            .rld_q  (rld_v[k]),
            .ctl_rd (ctl_v[k]),
            .tick   (ch_tick[k]),
            .uflow  (ch_uflow[k]),
            .flag   (ch_flag[k]),
            .irq    (irq[k])
        );
    end
endmodule

// File: rtl/dtu_checker.sv
`timescale 1ns/1ps
// dtu_checker: temporal properties of each timer channel, bound to dtimer_unit.
module dtu_checker #(
    parameter int NCH = 2,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         run_q,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         uflow,
    input logic [NCH-1:0]         flag,
    input logic [NCH-1:0]         cnt_we,
    input logic [NCH-1:0]         ctl_we,
    input logic [NCH-1:0][DW-1:0] cnt_v,
    input logic [NCH-1:0][DW-1:0] rld_v,
    input logic [DW-1:0]          bus_wdata,
    input logic [NCH-1:0]         irq
);
    for (genvar k = 0; k < NCH; k++) begin : g_prop
        assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[k] && !cnt_we[k]) |=> $stable(cnt_v[k]));

        assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[k] && tick[k] && !cnt_we[k] && cnt_v[k] != '0)
            |=> cnt_v[k] == $past(cnt_v[k]) - DW'(1));

        assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
            uflow[k] |=> (cnt_v[k] == $past(rld_v[k])) && flag[k]);

        assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[k] && !ctl_we[k]) |=> flag[k]);

        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (uflow[k] && ctl_we[k]) |=> flag[k]);

        assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |-> flag[k]);

        assert_direct_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_we[k] |=> cnt_v[k] == $past(bus_wdata));
    end
endmodule

bind dtimer_unit dtu_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .tick      (ch_tick),
    .uflow     (ch_uflow),
    .flag      (ch_flag),
    .cnt_we    (cnt_we),
    .ctl_we    (ctl_we),
    .cnt_v     (cnt_v),
    .rld_v     (rld_v),
    .bus_wdata (bus_wdata),
    .irq       (irq)
);

// File: tb/test_dtimer_unit.sv
`timescale 1ns/1ps
// test_dtimer_unit: behavioural reference model compared on every clock,
// plus directed checks for each requirement.
module test_dtimer_unit;
    localparam logic [7:0] A_START = 8'h00;
    localparam logic [7:0] A_CNT0 = 8'h04, A_RLD0 = 8'h08, A_CTL0 = 8'h0C;
    localparam logic [7:0] A_CNT1 = 8'h14, A_RLD1 = 8'h18, A_CTL1 = 8'h1C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_cnt [2];
    logic [31:0] m_rld [2];
    int          m_sel [2];
    bit          m_ie  [2];
    bit          m_flag[2];
    bit   [1:0]  m_run;
    int          m_pre;

    dtimer_unit i_dtimer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int divof(input int s);
        return 4 << (2 * s);
    endfunction

    function automatic bit tick_now(input int k);
        return (m_pre % divof(m_sel[k])) == divof(m_sel[k]) - 1;
    endfunction

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        if (a == A_START) r[1:0] = m_run;
        for (int k = 0; k < 2; k++) begin
            if (a == 8'(4 + 16*k))  r = m_cnt[k];
            if (a == 8'(8 + 16*k))  r = m_rld[k];
            if (a == 8'(12 + 16*k)) begin
                r[2:0] = 3'(m_sel[k]);
                r[5]   = m_ie[k];
                r[8]   = m_flag[k];
            end
        end
        return r;
    endfunction

    // Model update at each edge, then compare every clock.
    always @(posedge clk) begin
        bit tk, uf, wc, wr, wt;
        cyc++;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = '1; m_rld[k] = '1; m_sel[k] = 0; m_ie[k] = 0; m_flag[k] = 0;
            end
            m_run = 0;
            m_pre = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                tk = tick_now(k);
                wc = bus_we && bus_addr == 8'(4 + 16*k);
                wr = bus_we && bus_addr == 8'(8 + 16*k);
                wt = bus_we && bus_addr == 8'(12 + 16*k);
                uf = m_run[k] && tk && m_cnt[k] == 0 && !wc;
                if (wc) m_cnt[k] = bus_wdata;
                else if (m_run[k] && tk) m_cnt[k] = (m_cnt[k] == 0) ? m_rld[k] : m_cnt[k] - 1;
                if (wr) m_rld[k] = bus_wdata;
                m_flag[k] = uf || (m_flag[k] && !(wt && !bus_wdata[8]));
                if (wt) begin
                    m_sel[k] = int'(bus_wdata[2:0]);
                    m_ie[k]  = bus_wdata[5];
                end
            end
            if (bus_we && bus_addr == A_START) m_run = bus_wdata[1:0];
            m_pre = (m_pre + 1) % 65536;
        end
        #1;
        check(cur_req, bus_rdata, rd_model(bus_addr));
        for (int k = 0; k < 2; k++)
            check("R7", 32'(irq[k]), 32'(m_flag[k] && m_ie[k]));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_irq(input int k, output bit ok);
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq[k]) begin ok = 1; return; end
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, v0, v1, b0, b1;
        bit ok;
        int t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        cur_req = "R1";
        rd(A_CNT0, v);  check("R1", v, 32'hFFFF_FFFF);
        rd(A_RLD0, v);  check("R1", v, 32'hFFFF_FFFF);
        rd(A_CTL0, v);  check("R1", v, 32'h0);
        rd(A_CNT1, v);  check("R1", v, 32'hFFFF_FFFF);
        rd(A_RLD1, v);  check("R1", v, 32'hFFFF_FFFF);
        rd(A_CTL1, v);  check("R1", v, 32'h0);
        rd(A_START, v); check("R1", v, 32'h0);
        check("R1", 32'(irq), 32'h0);

        // R10: unmapped addresses
        cur_req = "R10";
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        peek(8'h10, v);  check("R10", v, 32'h0);
        peek(A_START, v); check("R10", v, 32'h0);
        peek(A_CTL0, v); check("R10", v, 32'h0);

        // R4: periodic expiry with reload 5 at /4
        cur_req = "R4";
        wr(A_CTL0, 32'h20);
        wr(A_RLD0, 32'd5);
        wr(A_CNT0, 32'd5);
        wr(A_START, 32'h1);
        wait_irq(0, ok); check("R4", 32'(ok), 32'h1);
        t1 = cyc;
        peek(A_CNT0, v); check("R4", v, 32'd5);
        peek(A_CTL0, v); check("R4", v, 32'h120);
        cur_req = "R5";
        wr(A_CTL0, 32'h20);
        peek(A_CTL0, v); check("R5", v, 32'h20);
        cur_req = "R4";
        wait_irq(0, ok); check("R4", 32'(ok), 32'h1);
        t2 = cyc;
        check("R4", 32'(t2 - t1), 32'd24);

        // R8: direct counter write
        cur_req = "R8";
        wr(A_CNT0, 32'h100);
        peek(A_CNT0, v); check("R8", v, 32'h100);

        // R2: freeze while stopped
        cur_req = "R2";
        wr(A_START, 32'h0);
        peek(A_CNT0, v0);
        repeat (40) @(negedge clk);
        peek(A_CNT0, v1); check("R2", v1, v0);

        // R9: single-shot on channel 1 at /16
        cur_req = "R9";
        wr(A_CTL1, 32'h21);
        wr(A_RLD1, 32'h0);
        wr(A_CNT1, 32'd2);
        wr(A_START, 32'h2);
        repeat (100) @(negedge clk);
        peek(A_CNT1, v); check("R9", v, 32'h0);
        peek(A_CTL1, v); check("R9", v, 32'h121);
        check("R7", 32'(irq[1]), 32'h1);

        // R5: write with bit 8 set keeps flag; bit 8 clear clears it
        cur_req = "R5";
        wr(A_START, 32'h0);
        wr(A_CTL1, 32'h101);
        peek(A_CTL1, v); check("R5", v, 32'h101);
        check("R7", 32'(irq[1]), 32'h0);
        wr(A_CTL1, 32'h001);
        peek(A_CTL1, v); check("R5", v, 32'h001);

        // R11 and R3: channel 1 free-running at /16, channel 0 stopped
        cur_req = "R11";
        wr(A_RLD1, 32'hFFFF_FFFF);
        wr(A_CNT1, 32'hFFFF_FFFF);
        wr(A_START, 32'h2);
        peek(A_CNT0, v0);
        peek(A_CNT1, b0);
        repeat (64) @(negedge clk);
        peek(A_CNT0, v1);
        peek(A_CNT1, b1);
        check("R11", v1, v0);
        check("R3", b0 - b1, 32'd4);

        // R3: channel 0 at /4 counts ten ticks in forty cycles
        cur_req = "R3";
        wr(A_CTL0, 32'h0);
        wr(A_CNT0, 32'hFFFF_FFFF);
        wr(A_START, 32'h3);
        peek(A_CNT0, v0);
        repeat (40) @(negedge clk);
        peek(A_CNT0, v1);
        check("R3", v0 - v1, 32'd10);
        check("R3", (~v1) - (~v0), 32'd10);

        // R6: clearing write on the same edge as an expiry
        cur_req = "R6";
        wr(A_CTL0, 32'h20);
        wr(A_RLD0, 32'd3);
        wr(A_CNT0, 32'd3);
        wait_irq(0, ok); check("R6", 32'(ok), 32'h1);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (m_cnt[0] == 0 && tick_now(0)) begin ok = 1; break; end
        end
        check("R6", 32'(ok), 32'h1);
        bus_we = 1; bus_addr = A_CTL0; bus_wdata = 32'h20;
        @(negedge clk);
        bus_we = 0;
        peek(A_CTL0, v); check("R6", v, 32'h120);
        peek(A_CNT0, v); check("R6", v, 32'd3);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule